// File: doc/BRIEF.md
# Look-Ahead Decimal Digit Adder

This block adds two packed BCD numbers plus a carry-in and returns a packed BCD sum and a decimal carry-out. Each decimal digit is formed by one digit cell that produces its sum digit and its carry directly from flat look-ahead terms. The cell does not first make a 4-bit binary sum and then correct it by adding six.

Inside a digit cell, per-bit and, or and xor terms of the two operand digits feed a small group stage. That stage treats the upper three bits of each digit as one weighted quantity U and flags two windows: U of five or more, and U equal to four. The carry out of bit 0 then picks one of two precomputed candidates for the upper three sum bits. The carry-out is also formed from the group flags, so it never waits on a binary add.

Digit cells are chained through their decimal carries to build a multi-digit adder. The chained result is captured in output registers that reset synchronously, so the block fits into a pipelined datapath with one cycle of latency.

Top module: `bcd_la_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` and `carry_o` become all zeros at that edge.
- R2: Bit 0 of each sum digit equals the xor of bit 0 of both operand digits and that digit's carry-in.
- R3: When bit 0 of a digit produces no carry (both bit-0 inputs low), the digit carries out exactly when U = a[3:1] + b[3:1] is 5 or more.
- R4: When U equals 4, the digit carries out only if bit 0 carries (a[0] + b[0] + carry-in is 2 or more).
- R5: For valid digits (0 to 9), each sum digit equals (a + b + carry-in) mod 10.
- R6: For valid digits, a digit's decimal carry-out is 1 exactly when a + b + carry-in is 10 or more.
- R7: Digit i occupies bits [4i+3:4i], with the least significant digit in bits [3:0]. The carry-out of digit i is the carry-in of digit i+1, `carry_i` enters digit 0, and `carry_o` is the carry-out of the top digit. The full result is the decimal sum modulo 10^DIGITS.
- R8: Outputs are registered. A change on the inputs shows on `sum_o` and `carry_o` after the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa_i | input | 4*DIGITS | First packed BCD operand |
| opb_i | input | 4*DIGITS | Second packed BCD operand |
| carry_i | input | 1 | Decimal carry into digit 0 |
| sum_o | output | 4*DIGITS | Registered packed BCD sum |
| carry_o | output | 1 | Registered decimal carry out of the top digit |

## Verification
The hardest case to reach is the boundary where the upper bits weigh exactly four. There the carry depends only on the bit-0 carry, and a wrong group-propagate term stays hidden unless a[0], b[0] and the carry-in are set to the right values at the same time. The bench drives all 200 valid digit/carry combinations through digit 0 with the upper digits at zero, so digit 1 shows the digit carry. It then adds directed cases at the U=4 and U=5 edges. Long carry ripples such as 9999+0000+1 and random four-digit operands exercise the chaining.

// File: rtl/bcd_la_pkg.sv
package bcd_la_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  function automatic logic digit_ok(input bcd_digit_t d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd_la_bitterms.sv
module bcd_la_bitterms
  import bcd_la_pkg::*;
(
  input  bcd_digit_t a,
  input  bcd_digit_t b,
  output bcd_digit_t g,
  output bcd_digit_t p,
  output bcd_digit_t h
);
  for (genvar j = 0; j < DIGIT_W; j++) begin : g_bit
    assign g[j] = a[j] & b[j];
    assign p[j] = a[j] | b[j];
    assign h[j] = a[j] ^ b[j];
  end
endmodule

// File: rtl/bcd_la_group.sv
module bcd_la_group (
  input  logic [2:0] gu,
  input  logic [2:0] pu,
  input  logic [2:0] hu,
  output logic       k,
  output logic       l,
  output logic [3:0] u
);
  logic c2;

  always_comb begin
    // upper weight reaches five or more
    k = gu[2] | (pu[2] & (pu[1] | pu[0])) | (gu[1] & pu[0]);
    // upper weight is exactly four
    l = (hu[2] & ~pu[1] & ~pu[0]) |
        (~pu[2] & ((gu[1] & ~pu[0]) | (hu[1] & gu[0])));
    c2   = gu[1] | (pu[1] & gu[0]);
    u[0] = hu[0];
    u[1] = hu[1] ^ gu[0];
    u[2] = hu[2] ^ c2;
    u[3] = gu[2] | (pu[2] & c2);
  end

  logic [3:0] u_ref;
  assign u_ref = ({2'b00, gu[2], 1'b0} + {2'b00, pu[2], 1'b0}) * 4'd2
               + {2'b00, gu[1], 1'b0} + {2'b00, pu[1], 1'b0}
               + {3'b000, gu[0]} + {3'b000, pu[0]};

  always_comb begin
    if (!$isunknown({gu, pu, hu})) begin
      // R3
      upper_weight_chk: assert (u == u_ref);
    end
  end
endmodule

// File: rtl/bcd_la_digit.sv
module bcd_la_digit
  import bcd_la_pkg::*;
(
  input  bcd_digit_t a,
  input  bcd_digit_t b,
  input  logic       cin,
  output bcd_digit_t s,
  output logic       cout
);
  bcd_digit_t g, p, h;
  logic       k, l, kl, c1;
  logic [3:0] u;
  logic [2:0] up_c0, up_c1;

  bcd_la_bitterms bits_i (.a(a), .b(b), .g(g), .p(p), .h(h));

  bcd_la_group grp_i (
    .gu(g[3:1]), .pu(p[3:1]), .hu(h[3:1]),
    .k(k), .l(l), .u(u)
  );

  always_comb begin
    c1 = g[0] | (p[0] & cin);
    kl = k | l;
    // candidate upper bits when bit 0 does not carry
    up_c0[0] = h[1] ^ k;
    up_c0[1] = k ? (u[3] | (u[1] & u[0])) : u[1];
    up_c0[2] = u[2] & ~k;
    // candidate upper bits when bit 0 carries
    up_c1[0] = ~(u[0] ^ kl);
    up_c1[1] = kl ? u[1] : (u[1] ^ u[0]);
    up_c1[2] = kl ? u[3] : (u[1] & u[0]);
    s[0]    = h[0] ^ cin;
    s[3:1]  = c1 ? up_c1 : up_c0;
    cout    = k | (l & c1);
  end

  logic [3:0] u_sum;
  assign u_sum = {1'b0, a[3:1]} + {1'b0, b[3:1]};

  always_comb begin
    if (!$isunknown({a, b}) && digit_ok(a) && digit_ok(b)) begin
      // R3
      k_window_chk: assert (k == (u_sum >= 4'd5));
      // R4
      l_window_chk: assert (l == (u_sum == 4'd4));
    end
  end
endmodule

// File: rtl/bcd_la_chain.sv
module bcd_la_chain
  import bcd_la_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGIT_W * DIGITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [DIGITS:0] dc;
  assign dc[0] = cin;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    bcd_la_digit dig_i (
      .a   (opa[DIGIT_W*i +: DIGIT_W]),
      .b   (opb[DIGIT_W*i +: DIGIT_W]),
      .cin (dc[i]),
      .s   (sum[DIGIT_W*i +: DIGIT_W]),
      .cout(dc[i+1])
    );
  end

  assign cout = dc[DIGITS];
endmodule

// File: rtl/bcd_la_adder.sv
module bcd_la_adder
  import bcd_la_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGIT_W * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         carry_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] sum_c;
  logic         cout_c;

  bcd_la_chain #(.DIGITS(DIGITS)) chain_i (
    .opa(opa_i), .opb(opb_i), .cin(carry_i),
    .sum(sum_c), .cout(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= sum_c;
      carry_o <= cout_c;
    end
  end

  // ---------------- checking ----------------
  function automatic longint unsigned pow10(input int n);
    longint unsigned r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  localparam longint unsigned MODV = pow10(DIGITS);

  function automatic longint unsigned dec_val(input logic [W-1:0] v);
    longint unsigned acc = 0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * 10 + 64'(v[DIGIT_W*i +: DIGIT_W]);
    return acc;
  endfunction

  function automatic logic all_ok(input logic [W-1:0] v);
    logic r = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      r = r & digit_ok(v[DIGIT_W*i +: DIGIT_W]);
    return r;
  endfunction

  logic            primed;
  logic            in_ok;
  longint unsigned in_total;
  longint unsigned out_total;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assign in_ok     = all_ok(opa_i) & all_ok(opb_i);
  assign in_total  = dec_val(opa_i) + dec_val(opb_i) + 64'(carry_i);
  assign out_total = dec_val(sum_o) + (carry_o ? MODV : 64'd0);

  // R2
  lsb_parity_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> sum_o[0] == $past(opa_i[0] ^ opb_i[0] ^ carry_i));

  // R5
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(in_ok)) |-> all_ok(sum_o));

  // R7
  total_value_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(in_ok)) |-> out_total == $past(in_total));

  // R6
  carry_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(in_ok)) |-> carry_o == ($past(in_total) >= MODV));
endmodule

// File: tb/bcd_la_adder_tb_top.sv
module bcd_la_adder_tb_top;
  localparam int ND = 4;
  localparam int W  = 4 * ND;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_la_adder #(.DIGITS(ND)) dut_i (
    .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .carry_i(cin),
    .sum_o(sum), .carry_o(cout)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int x = v;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(negedge clk);
    opa = a; opb = b; cin = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    opa = to_bcd(9999); opb = to_bcd(9999); cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sum under reset", int'(sum), 0);
    check("R1 carry under reset", int'(cout), 0);
    rst = 1'b0;
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++) begin
          apply(to_bcd(a), to_bcd(b), c[0]);
          check("R5 digit sum", int'(sum[3:0]), (a + b + c) % 10);
          check("R6 digit carry", int'(sum[7:4]), (a + b + c) / 10);
          check("R2 bit0 parity", int'(sum[0]), (a ^ b ^ c) & 1);
        end
  endtask

  task automatic t_group();
    // R3: bit-0 inputs clear, no bit-0 carry; U = 4 vs 5
    apply(to_bcd(8), to_bcd(2), 1'b0);   // U=5
    check("R3 U=5 carries", int'(sum[7:4]), 1);
    apply(to_bcd(6), to_bcd(2), 1'b0);   // U=4, no bit-0 carry
    check("R3 U=4 no carry", int'(sum[7:4]), 0);
    apply(to_bcd(4), to_bcd(4), 1'b0);   // U=4
    check("R3 U=4 sum", int'(sum[3:0]), 8);
    // R4: U=4 decided by bit-0 carry
    apply(to_bcd(8), to_bcd(1), 1'b1);
    check("R4 U=4 with bit0 carry", int'(sum[7:4]), 1);
    check("R4 U=4 with bit0 carry digit", int'(sum[3:0]), 0);
    apply(to_bcd(8), to_bcd(1), 1'b0);
    check("R4 U=4 single bit0 one", int'(sum[7:4]), 0);
    apply(to_bcd(8), to_bcd(0), 1'b1);
    check("R4 U=4 cin only", int'(sum[7:4]), 0);
    apply(to_bcd(5), to_bcd(5), 1'b0);
    check("R4 U=4 both bit0", int'(sum[7:4]), 1);
  endtask

  task automatic t_chain();
    apply(to_bcd(9999), to_bcd(0), 1'b1);
    check("R7 full ripple sum", int'(sum), 0);
    check("R7 full ripple carry", int'(cout), 1);
    apply(to_bcd(9999), to_bcd(9999), 1'b1);
    check("R7 max sum", int'(sum), int'(to_bcd(9999)));
    check("R7 max carry", int'(cout), 1);
    for (int n = 0; n < 40; n++) begin
      int x = int'($urandom % 10000);
      int y = int'($urandom % 10000);
      int c = int'($urandom % 2);
      apply(to_bcd(x), to_bcd(y), c[0]);
      check("R7 random sum", int'(sum), int'(to_bcd((x + y + c) % 10000)));
      check("R7 random carry", int'(cout), ((x + y + c) >= 10000) ? 1 : 0);
    end
  endtask

  task automatic t_latency();
    apply(to_bcd(1234), to_bcd(1111), 1'b0);
    check("R8 first result", int'(sum), int'(to_bcd(2345)));
    opa = to_bcd(5000); opb = to_bcd(5000); cin = 1'b0;
    #2;
    check("R8 holds before edge", int'(sum), int'(to_bcd(2345)));
    check("R8 carry holds before edge", int'(cout), 0);
    @(negedge clk);
    check("R8 updated sum", int'(sum), 0);
    check("R8 updated carry", int'(cout), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_exhaustive();
    t_group();
    t_chain();
    t_latency();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule